// File: doc/BRIEF.md
# Misaligned Access Splitting Memory Adapter

This adapter sits between a load/store request port and a memory whose port is eight bytes wide and takes only word addresses. A request names a byte address, a size of 1, 2, 4 or 8 bytes, a direction, and for stores the data. The adapter turns each request into aligned word transactions. A load that spans two words is fetched as two word reads, and the wanted bytes are joined and right-justified. A store that does not cover a whole aligned word is done as read-merge-write on each word it touches. Memory has no byte strobes, so this is the only way to write part of a word.

A fault-mode input makes the adapter refuse any access whose address is not a multiple of its own size. Such a request completes at once with an error flag and causes no memory transaction. The block serves one request at a time. The controller is a state machine with these states:
- `S_IDLE`: waiting for a request.
- `S_RD_LO` / `S_WAIT_LO`: issue the lower-word read, then wait for its data.
- `S_RD_HI` / `S_WAIT_HI`: issue the upper-word read, then wait for its data.
- `S_WR_LO` / `S_WR_HI`: write the merged words back.
- `S_DONE`: one-cycle response.

The transitions are:
- IDLE→DONE when a request is refused.
- IDLE→WR_LO for a full aligned store.
- IDLE→RD_LO for every other request.
- RD_LO→WAIT_LO and RD_HI→WAIT_HI when memory accepts the read.
- WAIT_LO→RD_HI when the access crosses into the next word.
- WAIT_LO→WR_LO for a store that stays in one word.
- WAIT_LO→DONE for a load that stays in one word.
- WAIT_HI→WR_LO for a store.
- WAIT_HI→DONE for a load.
- WR_LO→WR_HI when the store crosses a word boundary.
- WR_LO→DONE when it does not.
- WR_HI→DONE.
- DONE→IDLE.

Top module: `split_mem_adapter`

## Requirements
- R1: The memory address is the byte address shifted right by 3. While a memory request waits for `mem_ready`, its address, direction and data stay stable.
- R2: Byte order is little-endian. A load returns its bytes right-justified in `rsp_rdata`: the byte at the request address goes in bits 7:0, and all bits above the requested size are zero. Size codes: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8.
- R3: A load with (addr[2:0] + bytes) ≤ 8 performs exactly one memory read and no write.
- R4: A load with (addr[2:0] + bytes) > 8 reads the word at addr>>3 first, then the next word, and returns the bytes from both.
- R5: A store of 8 bytes with addr[2:0] = 0 is done as one memory write with no read.
- R6: Any other store contained in one word reads that word, replaces only the target bytes and writes it back (one read, one write).
- R7: A store that crosses a word boundary reads both words, then writes both back merged (two reads, two writes), leaving all other bytes unchanged.
- R8: With `fault_mode` = 1, a request whose addr[2:0] is not a multiple of its byte count produces no memory transaction. Memory is left unchanged, and the request completes with `rsp_misaligned` = 1 and `rsp_rdata` = 0.
- R9: With `fault_mode` = 1, size-aligned accesses are performed normally. With `fault_mode` = 0, misaligned accesses never raise `rsp_misaligned`.
- R10: `req_ready` is high only when no request is in progress. `rsp_valid` is a one-cycle pulse that ends each request. After reset the block is idle, with no memory request and no response.
- R11: The second word of a crossing access is at the next word address modulo 2^(ADDR_W-3). The wrap raises no error.
- R12: Correct results hold for any read latency of one or more cycles, and for any number of cycles in which `mem_ready` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter idle; request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Byte count code: 0=1, 1=2, 2=4, 3=8 |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8*WB | Store data, right-justified |
| fault_mode | input | 1 | 1 = refuse size-misaligned requests |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*WB | Load result, zero-extended |
| rsp_misaligned | output | 1 | Request refused as misaligned |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request |
| mem_write | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | ADDR_W-3 | Word address |
| mem_wdata | output | 8*WB | Word write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8*WB | Read data word |

## Verification
A table of loads and stores covers several address patterns, and each one separates a different path:
- Loads at aligned addresses, at offsets inside a word, and at offsets that spill into the next word separate the one-read and two-read paths.
- Full aligned stores, partial stores inside a word and boundary-crossing stores separate the 1, 2 and 4 transaction sequences. The counts of memory reads and writes are checked for each.
- Loads after each store, checked against a byte-level shadow memory, show whether merging disturbed neighbouring bytes.

Other entries run with fault mode on, using both misaligned and size-aligned addresses, to separate refusal from normal handling. Accesses at the top of the address space show the wrap to word zero. A run with slow read data and an intermittent `mem_ready` shows that the controller waits rather than counting cycles.

// File: rtl/splt_pkg.sv
package splt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_LO,
        S_WAIT_LO,
        S_RD_HI,
        S_WAIT_HI,
        S_WR_LO,
        S_WR_HI,
        S_DONE
    } splt_state_e;

endpackage

// File: rtl/splt_plan.sv
// Decodes a request address and size into word address, offset, byte count
// and the boundary / alignment flags the controller branches on.
module splt_plan #(
    parameter int ADDR_W = 32,
    parameter int WB     = 8,
    localparam int OFF_W = $clog2(WB),
    localparam int WA_W  = ADDR_W - OFF_W,
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    output logic [OFF_W-1:0]  off_o,
    output logic [CNT_W-1:0]  nbytes_o,
    output logic [WA_W-1:0]   wlo_o,
    output logic              cross_o,
    output logic              misalign_o,
    output logic              full_o
);

    logic [CNT_W-1:0] end_pos;
    logic [OFF_W-1:0] size_mask;

    always_comb begin
        nbytes_o   = CNT_W'(1) << size_i;
        off_o      = addr_i[OFF_W-1:0];
        wlo_o      = addr_i[ADDR_W-1:OFF_W];
        end_pos    = {1'b0, off_o} + nbytes_o;
        cross_o    = end_pos > CNT_W'(WB);
        size_mask  = nbytes_o[OFF_W-1:0] - OFF_W'(1);
        misalign_o = (off_o & size_mask) != '0;
        full_o     = (nbytes_o == CNT_W'(WB)) && (off_o == '0);
    end

    // R4: a crossing access can never start on a word boundary
    always_comb begin
        if (cross_o) begin
            assert_cross_offset_R4: assert (off_o != '0);
        end
    end

endmodule

// File: rtl/splt_bytes.sv
// Byte lane network: extracts load bytes from a word pair and merges store
// bytes into a word pair, both little-endian.
module splt_bytes #(
    parameter int WB = 8,
    localparam int DW    = 8 * WB,
    localparam int OFF_W = $clog2(WB),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [DW-1:0]    lo_i,
    input  logic [DW-1:0]    hi_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [DW-1:0]    new_lo_o,
    output logic [DW-1:0]    new_hi_o
);

    logic [2*DW-1:0] pair;
    logic [2*DW-1:0] merged;

    assign pair = {hi_i, lo_i};

    for (genvar j = 0; j < 2 * WB; j++) begin : g_merge
        logic [7:0] lane;
        always_comb begin
            int rel;
            rel = j - int'(off_i);
            if (rel >= 0 && rel < int'(nbytes_i)) begin
                lane = 8'(wdata_i >> (8 * rel));
            end else begin
                lane = pair[j*8 +: 8];
            end
        end
        assign merged[j*8 +: 8] = lane;
    end

    for (genvar i = 0; i < WB; i++) begin : g_extract
        logic [7:0] lane;
        always_comb begin
            if (i < int'(nbytes_i)) begin
                lane = 8'(pair >> (8 * (int'(off_i) + i)));
            end else begin
                lane = 8'h00;
            end
        end
        assign rdata_o[i*8 +: 8] = lane;
    end

    assign new_lo_o = merged[DW-1:0];
    assign new_hi_o = merged[2*DW-1:DW];

endmodule

// File: rtl/split_mem_adapter.sv
module split_mem_adapter
    import splt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WB     = 8,
    localparam int DW    = 8 * WB,
    localparam int OFF_W = $clog2(WB),
    localparam int WA_W  = ADDR_W - OFF_W,
    localparam int CNT_W = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              fault_mode,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic              rsp_misaligned,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [WA_W-1:0]   mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata
);

    splt_state_e state_q, state_d;

    logic             wr_q, cross_q, full_q, err_q;
    logic [OFF_W-1:0] off_q;
    logic [CNT_W-1:0] nb_q;
    logic [WA_W-1:0]  wlo_q;
    logic [DW-1:0]    wdata_q, lo_q, hi_q;

    logic [OFF_W-1:0] p_off;
    logic [CNT_W-1:0] p_nb;
    logic [WA_W-1:0]  p_wlo;
    logic             p_cross, p_misalign, p_full;
    logic [DW-1:0]    ext_rdata, new_lo, new_hi;
    logic             accept, refuse;

    splt_plan #(.ADDR_W(ADDR_W), .WB(WB)) u_plan (
        .addr_i     (req_addr),
        .size_i     (req_size),
        .off_o      (p_off),
        .nbytes_o   (p_nb),
        .wlo_o      (p_wlo),
        .cross_o    (p_cross),
        .misalign_o (p_misalign),
        .full_o     (p_full)
    );

    splt_bytes #(.WB(WB)) u_bytes (
        .lo_i     (lo_q),
        .hi_i     (hi_q),
        .off_i    (off_q),
        .nbytes_i (nb_q),
        .wdata_i  (wdata_q),
        .rdata_o  (ext_rdata),
        .new_lo_o (new_lo),
        .new_hi_o (new_hi)
    );

    assign accept = req_valid && (state_q == S_IDLE);
    assign refuse = fault_mode && p_misalign;

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wr_q    <= 1'b0;
            cross_q <= 1'b0;
            full_q  <= 1'b0;
            err_q   <= 1'b0;
            off_q   <= '0;
            nb_q    <= '0;
            wlo_q   <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                wr_q    <= req_write;
                cross_q <= p_cross;
                full_q  <= p_full;
                err_q   <= refuse;
                off_q   <= p_off;
                nb_q    <= p_nb;
                wlo_q   <= p_wlo;
                wdata_q <= req_wdata;
            end
            if (state_q == S_WAIT_LO && mem_rvalid) begin
                lo_q <= mem_rdata;
            end
            if (state_q == S_WAIT_HI && mem_rvalid) begin
                hi_q <= mem_rdata;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (refuse) begin
                        state_d = S_DONE;
                    end else if (req_write && p_full) begin
                        state_d = S_WR_LO;
                    end else begin
                        state_d = S_RD_LO;
                    end
                end
            end
            S_RD_LO: begin
                if (mem_ready) state_d = S_WAIT_LO;
            end
            S_WAIT_LO: begin
                if (mem_rvalid) begin
                    if (cross_q)   state_d = S_RD_HI;
                    else if (wr_q) state_d = S_WR_LO;
                    else           state_d = S_DONE;
                end
            end
            S_RD_HI: begin
                if (mem_ready) state_d = S_WAIT_HI;
            end
            S_WAIT_HI: begin
                if (mem_rvalid) state_d = wr_q ? S_WR_LO : S_DONE;
            end
            S_WR_LO: begin
                if (mem_ready) state_d = cross_q ? S_WR_HI : S_DONE;
            end
            S_WR_HI: begin
                if (mem_ready) state_d = S_DONE;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready      = (state_q == S_IDLE);
        mem_valid      = 1'b0;
        mem_write      = 1'b0;
        mem_addr       = wlo_q;
        mem_wdata      = '0;
        rsp_valid      = 1'b0;
        rsp_misaligned = 1'b0;
        rsp_rdata      = '0;
        unique case (state_q)
            S_RD_LO: begin
                mem_valid = 1'b1;
            end
            S_RD_HI: begin
                mem_valid = 1'b1;
                mem_addr  = wlo_q + WA_W'(1);
            end
            S_WR_LO: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_wdata = new_lo;
            end
            S_WR_HI: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = wlo_q + WA_W'(1);
                mem_wdata = new_hi;
            end
            S_DONE: begin
                rsp_valid      = 1'b1;
                rsp_misaligned = err_q;
                if (!wr_q && !err_q) rsp_rdata = ext_rdata;
            end
            default: ;
        endcase
    end

    assert_mem_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_write) && $stable(mem_wdata));

    assert_no_read_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_LO) |-> !(wr_q && full_q));

    assert_refused_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !mem_valid);

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_HI) && ($past(state_q) != S_RD_HI) |-> $past(state_q) == S_WAIT_LO);

endmodule

// File: tb/split_mem_adapter_bench.sv
`timescale 1ns/1ps
module split_mem_adapter_bench;

    localparam int ADDR_W = 32;
    localparam int WB     = 8;
    localparam int DW     = 64;
    localparam int WA_W   = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic              fault_mode = 1'b0;
    logic              rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_misaligned;
    logic              mem_valid;
    logic              mem_ready;
    logic              mem_write;
    logic [WA_W-1:0]   mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic              mem_rvalid = 1'b0;
    logic [DW-1:0]     mem_rdata = '0;

    always #2.5 clk = ~clk;

    split_mem_adapter #(.ADDR_W(ADDR_W), .WB(WB)) u_split_mem_adapter (
        .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_size, .req_addr,
        .req_wdata, .fault_mode, .rsp_valid, .rsp_rdata, .rsp_misaligned,
        .mem_valid, .mem_ready, .mem_write, .mem_addr, .mem_wdata,
        .mem_rvalid, .mem_rdata
    );

    // memory model: 16 words, word index = mem_addr[3:0]
    logic [DW-1:0] mem [0:15];
    logic [7:0]    shadow [0:127];
    int            rd_cnt = 0, wr_cnt = 0, pend = 0, lat = 1, cyc = 0;
    logic [DW-1:0] held = '0;
    bit            stall_en = 1'b0;

    assign mem_ready = !stall_en || cyc[0];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rvalid <= 1'b0;
        if (pend > 0) begin
            if (pend == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= held;
            end
            pend <= pend - 1;
        end
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                mem[mem_addr[3:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                held   <= mem[mem_addr[3:0]];
                pend   <= lat;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        w;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [63:0] wd;
        logic        fm;
        logic [2:0]  exp_rd;
        logic [2:0]  exp_wr;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:21] = '{
        '{1'b0, 2'd0, 32'h0000_0009, 64'h0, 1'b0, 3'd1, 3'd0, 4'd2},   // R2 byte inside word
        '{1'b0, 2'd3, 32'h0000_0008, 64'h0, 1'b0, 3'd1, 3'd0, 4'd3},   // R3 aligned 8-byte
        '{1'b0, 2'd3, 32'h0000_0009, 64'h0, 1'b0, 3'd2, 3'd0, 4'd4},   // R4 8-byte crossing
        '{1'b0, 2'd1, 32'h0000_0017, 64'h0, 1'b0, 3'd2, 3'd0, 4'd4},   // R4 2-byte crossing
        '{1'b0, 2'd2, 32'h0000_0024, 64'h0, 1'b0, 3'd1, 3'd0, 4'd3},   // R3 contained 4-byte
        '{1'b1, 2'd3, 32'h0000_0030, 64'h1122334455667788, 1'b0, 3'd0, 3'd1, 4'd5}, // R5
        '{1'b1, 2'd1, 32'h0000_0042, 64'hFFFF_FFFF_FFFF_A1B2, 1'b0, 3'd1, 3'd1, 4'd6}, // R6
        '{1'b1, 2'd2, 32'h0000_004E, 64'h0000_0000_C1C2C3C4, 1'b0, 3'd2, 3'd2, 4'd7}, // R7
        '{1'b1, 2'd3, 32'h0000_005B, 64'hD1D2D3D4D5D6D7D8, 1'b0, 3'd2, 3'd2, 4'd7},   // R7
        '{1'b0, 2'd3, 32'h0000_005B, 64'h0, 1'b0, 3'd2, 3'd0, 4'd7},   // R7 read back
        '{1'b0, 2'd3, 32'h0000_0048, 64'h0, 1'b0, 3'd1, 3'd0, 4'd7},   // R7 neighbours kept
        '{1'b0, 2'd2, 32'h0000_004E, 64'h0, 1'b1, 3'd0, 3'd0, 4'd8},   // R8 refused load
        '{1'b1, 2'd1, 32'h0000_0043, 64'hEEEE, 1'b1, 3'd0, 3'd0, 4'd8}, // R8 refused store
        '{1'b0, 2'd3, 32'h0000_0040, 64'h0, 1'b0, 3'd1, 3'd0, 4'd8},   // R8 memory untouched
        '{1'b0, 2'd2, 32'h0000_0044, 64'h0, 1'b1, 3'd1, 3'd0, 4'd9},   // R9 aligned in fault mode
        '{1'b0, 2'd0, 32'h0000_0001, 64'h0, 1'b1, 3'd1, 3'd0, 4'd9},   // R9 byte never misaligned
        '{1'b1, 2'd3, 32'h0000_0030, 64'h0102030405060708, 1'b1, 3'd0, 3'd1, 4'd9}, // R9
        '{1'b0, 2'd1, 32'h0000_0043, 64'h0, 1'b0, 3'd1, 3'd0, 4'd9},   // R9 misaligned, no fault
        '{1'b0, 2'd3, 32'hFFFF_FFFC, 64'h0, 1'b0, 3'd2, 3'd0, 4'd11},  // R11 wrap load
        '{1'b1, 2'd2, 32'hFFFF_FFFE, 64'h0000_0000_9A9B9C9D, 1'b0, 3'd2, 3'd2, 4'd11}, // R11
        '{1'b0, 2'd3, 32'hFFFF_FFF8, 64'h0, 1'b0, 3'd1, 3'd0, 4'd11},  // R11 top word
        '{1'b0, 2'd3, 32'h0000_0000, 64'h0, 1'b0, 3'd1, 3'd0, 4'd11}   // R11 word zero
    };

    task automatic run_op(input vec_t v);
        int            n, rd0, wr0, wait_cyc;
        bit            exp_err;
        logic [DW-1:0] exp_data;
        string         tag;
        tag      = $sformatf("R%0d", v.req);
        n        = 1 << v.sz;
        exp_err  = v.fm && ((int'(v.addr[2:0]) % n) != 0);
        exp_data = '0;
        if (!v.w && !exp_err) begin
            for (int b = 0; b < n; b++) begin
                exp_data[b*8 +: 8] = shadow[(v.addr + 32'(b)) & 32'd127];
            end
        end
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = v.w;
        req_size   = v.sz;
        req_addr   = v.addr;
        req_wdata  = v.wd;
        fault_mode = v.fm;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready while busy", 64'(req_ready), 64'd0);
        wait_cyc = 0;
        while (!rsp_valid && wait_cyc < 200) begin
            @(negedge clk);
            wait_cyc++;
        end
        check(rsp_valid == 1'b1, tag, "response seen", 64'(rsp_valid), 64'd1);
        check(rsp_misaligned == exp_err, tag, "misaligned flag",
              64'(rsp_misaligned), 64'(exp_err));
        check(rsp_rdata == exp_data, tag, "load data", rsp_rdata, exp_data);
        check(rd_cnt - rd0 == int'(v.exp_rd), tag, "memory reads",
              64'(rd_cnt - rd0), 64'(v.exp_rd));
        check(wr_cnt - wr0 == int'(v.exp_wr), tag, "memory writes",
              64'(wr_cnt - wr0), 64'(v.exp_wr));
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", "response pulse length", 64'(rsp_valid), 64'd0);
        if (v.w && !exp_err) begin
            for (int b = 0; b < n; b++) begin
                shadow[(v.addr + 32'(b)) & 32'd127] = v.wd[b*8 +: 8];
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = 8'(i * 7 + 3);
        for (int w = 0; w < 16; w++) begin
            for (int b = 0; b < 8; b++) mem[w][b*8 +: 8] = 8'((w * 8 + b) * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10", "reset ready", 64'(req_ready), 64'd1);
        check(mem_valid == 1'b0, "R10", "reset mem_valid", 64'(mem_valid), 64'd0);
        check(rsp_valid == 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6 R7 R8 R9 R11 through the vector table
        for (int k = 0; k < 22; k++) run_op(VECS[k]);

        // R12 slow read data and intermittent mem_ready
        lat      = 3;
        stall_en = 1'b1;
        run_op('{1'b1, 2'd2, 32'h0000_006E, 64'h0000_0000_5A6B7C8D, 1'b0, 3'd2, 3'd2, 4'd12});
        run_op('{1'b0, 2'd3, 32'h0000_006B, 64'h0, 1'b0, 3'd2, 3'd0, 4'd12});
        run_op('{1'b1, 2'd3, 32'h0000_0070, 64'hCAFE_F00D_0BAD_BEEF, 1'b0, 3'd0, 3'd1, 4'd12});
        lat      = 1;
        stall_en = 1'b0;

        // R1 R8 whole memory equals shadow (word address mapping, untouched bytes)
        for (int w = 0; w < 16; w++) begin
            logic [DW-1:0] e;
            for (int b = 0; b < 8; b++) e[b*8 +: 8] = shadow[w*8 + b];
            check(mem[w] == e, "R1", $sformatf("memory word %0d", w), mem[w], e);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule